// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Periodic Tick

This block keeps wall-clock time and a calendar date from a 128 Hz tick-enable input. A seconds divider counts tick pulses and advances the seconds field once per nominal second. A signed trim value adjusts the divider's length by a fraction of a tick per second, so a slow or fast oscillator can be corrected. Seconds carry into minutes, hours, day, month and a two-digit year. All fields are packed BCD. Month length and February in leap years are handled in hardware.

Software loads time, date and a six-field alarm through load strobes. The hour is kept internally in 24-hour form. A mode input selects whether the hour is shown in 24-hour form or in 12-hour form with a PM flag. Two sticky interrupt flags are provided. The alarm flag is set when every field matches the alarm after a seconds advance. The tick flag is set at one of eight selectable rates, from every tick up to once per 128 ticks.

Top module: `cal_rtc`

## Requirements
- R1: After reset, time reads 00:00:00, date reads day 01, month 01, year 00, and both flags are 0.
- R2: With trim 0, the seconds field advances once every 128 tick pulses. At 59 seconds it wraps to 00 and carries into minutes. At 59 minutes it wraps and carries into hours. Hour 23 wraps to 00 and carries into the day.
- R3: The day wraps to 01 after day 30 in months 04, 06, 09 and 11. It wraps after day 31 in the other months other than February. In February it wraps after day 28 when the year is not a multiple of 4. Each day wrap advances the month.
- R4: February has 29 days when the BCD year is a multiple of 4, including year 00. Month 12 day 31 wraps to month 01 day 01 and advances the year. Year 99 wraps to 00.
- R5: A load_time strobe writes time_in as {hour, minute, second} in 24-hour BCD. A load_date strobe writes date_in as {year, month, day}. Both take effect at the next clock edge. load_time also restarts the seconds divider, so the next advance comes 128 ticks later.
- R6: When mode_12h is 0, time_out[23:16] is the 24-hour BCD hour. When mode_12h is 1, time_out[23] is the PM flag and time_out[20:16] is the BCD hour 12, 01..11. Hour 00 reads 12 with PM 0, 11 reads 11 with PM 0, 12 reads 12 with PM 1, and 13 reads 01 with PM 1.
- R7: alarm_flag is set one cycle after a seconds advance that leaves all six fields equal to the loaded alarm. The alarm is loaded by load_alarm from alarm_time_in and alarm_date_in, in the same layout as R5. A mismatch in any field, including the date, leaves alarm_flag at 0.
- R8: tick_flag and alarm_flag stay at 1 until a one-cycle clr_tick or clr_alarm pulse clears them. If a set and a clear occur in the same cycle, the set wins.
- R9: tick_flag is set once every 2^tick_sel tick pulses, for tick_sel 0 to 7. This gives periods from 1/128 s to 1 s.
- R10: trim is a signed count in 1/64 of a tick. Each second lasts 128 ticks plus the accumulated whole ticks of trim, starting with the second after a change. Trim 64 gives 129-tick seconds. Trim -64 gives 127-tick seconds. Trim 32 alternates 128 and 129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 128 Hz tick enable, one cycle per pulse |
| mode_12h | input | 1 | 1 selects 12-hour display |
| tick_sel | input | 3 | Periodic tick rate select |
| trim | input | 8 | Signed seconds trim in 1/64 tick |
| load_time | input | 1 | Load time_in, restart divider |
| time_in | input | 24 | {hour, min, sec} BCD |
| load_date | input | 1 | Load date_in |
| date_in | input | 24 | {year, month, day} BCD |
| load_alarm | input | 1 | Load alarm fields |
| alarm_time_in | input | 24 | Alarm {hour, min, sec} BCD |
| alarm_date_in | input | 24 | Alarm {year, month, day} BCD |
| clr_tick | input | 1 | Clear tick_flag |
| clr_alarm | input | 1 | Clear alarm_flag |
| time_out | output | 24 | Displayed {hour, min, sec} |
| date_out | output | 24 | {year, month, day} |
| tick_flag | output | 1 | Sticky periodic tick flag |
| alarm_flag | output | 1 | Sticky alarm match flag |

## Verification
The bench loads times just before a midnight crossing on the last day of February in a leap year and in a common year. It does the same at the end of a 30-day month and on the last day of year 99. A wrong leap test or month table would show an extra or missing day, and a bad BCD carry would produce codes such as 0x5A.

The 12-hour hours 00, 11, 12 and 13 are read directly. A naive conversion would show 00 or misplace the PM flag. The alarm is also run against a time that matches while the date does not, which catches a compare that ignores the date.

Tick flag and seconds periods are measured in tick pulses for several rate selects and trim values. An off-by-one in the divider or the phase mask would show up as 127- or 129-tick periods.

// File: rtl/cal_rtc.sv
module cal_rtc #(
  parameter int NOM_TICKS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        mode_12h,
  input  logic [2:0]  tick_sel,
  input  logic [7:0]  trim,
  input  logic        load_time,
  input  logic [23:0] time_in,
  input  logic        load_date,
  input  logic [23:0] date_in,
  input  logic        load_alarm,
  input  logic [23:0] alarm_time_in,
  input  logic [23:0] alarm_date_in,
  input  logic        clr_tick,
  input  logic        clr_alarm,
  output logic [23:0] time_out,
  output logic [23:0] date_out,
  output logic        tick_flag,
  output logic        alarm_flag
);
  localparam int PW = $clog2(NOM_TICKS);

  logic [7:0] sc_q, mn_q, hr_q, dy_q, mo_q, yr_q;
  logic [47:0] alarm_q;
  logic [7:0] cnt_q, len_q;
  logic [5:0] acc_q;
  logic [PW-1:0] ph_q;
  logic upd_q;

  function automatic [7:0] bcd_inc(input [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic leap;
  assign leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                        : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);

  logic [7:0] last_day;
  always_comb begin
    case (mo_q)
      8'h02: last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default: last_day = 8'h31;
    endcase
  end

  logic sec_p, c_min, c_hr, c_day, c_mon, c_yr;
  assign sec_p = tick && !load_time && (cnt_q == len_q - 8'd1);
  assign c_min = sec_p && sc_q == 8'h59;
  assign c_hr  = c_min && mn_q == 8'h59;
  assign c_day = c_hr && hr_q == 8'h23;
  assign c_mon = c_day && dy_q == last_day;
  assign c_yr  = c_mon && mo_q == 8'h12;

  logic signed [8:0] csum;
  assign csum = $signed({3'b000, acc_q}) + $signed({trim[7], trim});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= 8'(NOM_TICKS);
      acc_q <= '0;
    end else if (load_time) begin
      cnt_q <= '0;
    end else if (sec_p) begin
      cnt_q <= '0;
      len_q <= 8'(NOM_TICKS) + {{5{csum[8]}}, csum[8:6]};
      acc_q <= csum[5:0];
    end else if (tick) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {hr_q, mn_q, sc_q} <= '0;
    end else if (load_time) begin
      {hr_q, mn_q, sc_q} <= time_in;
    end else if (sec_p) begin
      sc_q <= c_min ? 8'h00 : bcd_inc(sc_q);
      if (c_min) mn_q <= c_hr ? 8'h00 : bcd_inc(mn_q);
      if (c_hr)  hr_q <= c_day ? 8'h00 : bcd_inc(hr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {yr_q, mo_q, dy_q} <= {8'h00, 8'h01, 8'h01};
    end else if (load_date) begin
      {yr_q, mo_q, dy_q} <= date_in;
    end else if (c_day) begin
      dy_q <= c_mon ? 8'h01 : bcd_inc(dy_q);
      if (c_mon) mo_q <= c_yr ? 8'h01 : bcd_inc(mo_q);
      if (c_yr)  yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    end
  end

  logic [7:0] msk;
  logic tick_evt, al_hit;
  assign msk      = (8'd1 << tick_sel) - 8'd1;
  assign tick_evt = tick && ((ph_q & msk[PW-1:0]) == msk[PW-1:0]);
  assign al_hit   = upd_q && ({hr_q, mn_q, sc_q, yr_q, mo_q, dy_q} == alarm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= '0;
      upd_q      <= 1'b0;
      alarm_q    <= '0;
      tick_flag  <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (tick) ph_q <= ph_q + 1'b1;
      upd_q <= sec_p;
      if (load_alarm) alarm_q <= {alarm_time_in, alarm_date_in};
      if (tick_evt) tick_flag <= 1'b1;
      else if (clr_tick) tick_flag <= 1'b0;
      if (al_hit) alarm_flag <= 1'b1;
      else if (clr_alarm) alarm_flag <= 1'b0;
    end
  end

  logic [4:0] hb, hb12;
  logic [7:0] hdisp;
  assign hb   = 5'(hr_q[7:4]) * 5'd10 + 5'(hr_q[3:0]);
  assign hb12 = hb - 5'd12;
  always_comb begin
    if (hb == 5'd0)       hdisp = 8'h12;
    else if (hb < 5'd12)  hdisp = hr_q;
    else if (hb == 5'd12) hdisp = 8'h92;
    else if (hb12 >= 5'd10) hdisp = {4'h9, 4'(hb12 - 5'd10)};
    else                  hdisp = {4'h8, 4'(hb12)};
  end

  assign time_out = {mode_12h ? hdisp : hr_q, mn_q, sc_q};
  assign date_out = {yr_q, mo_q, dy_q};
endmodule

module cal_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_12h,
  input logic        load_time,
  input logic [23:0] time_in,
  input logic [7:0]  hr_q,
  input logic [7:0]  mn_q,
  input logic [7:0]  sc_q,
  input logic [7:0]  dy_q,
  input logic [23:0] time_out,
  input logic        clr_tick,
  input logic        clr_alarm,
  input logic        tick_flag,
  input logic        alarm_flag
);
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n) sc_q[3:0] <= 4'd9 && sc_q < 8'h60); // R2
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hr_q <= 8'h23); // R2
  AST_DAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) dy_q != 8'h00); // R3
  AST_LOAD_TIME: assert property (@(posedge clk) disable iff (!rst_n) load_time |=> {hr_q, mn_q, sc_q} == $past(time_in)); // R5
  AST_HOUR_12H: assert property (@(posedge clk) disable iff (!rst_n) mode_12h |-> time_out[20:16] != 5'd0); // R6
  AST_TICK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) tick_flag && !clr_tick |=> tick_flag); // R8
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) alarm_flag && !clr_alarm |=> alarm_flag); // R8
endmodule

bind cal_rtc cal_rtc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_12h(mode_12h), .load_time(load_time),
  .time_in(time_in), .hr_q(hr_q), .mn_q(mn_q), .sc_q(sc_q), .dy_q(dy_q),
  .time_out(time_out), .clr_tick(clr_tick), .clr_alarm(clr_alarm),
  .tick_flag(tick_flag), .alarm_flag(alarm_flag)
);

// File: tb/test_cal_rtc.sv
`timescale 1ns/1ps
module test_cal_rtc;
  logic clk = 0, rst_n = 0, tick = 0, mode_12h = 0;
  logic [2:0] tick_sel = 0;
  logic [7:0] trim = 0;
  logic load_time = 0, load_date = 0, load_alarm = 0, clr_tick = 0, clr_alarm = 0;
  logic [23:0] time_in = 0, date_in = 0, alarm_time_in = 0, alarm_date_in = 0;
  logic [23:0] time_out, date_out;
  logic tick_flag, alarm_flag;

  int checks = 0, errors = 0;
  int h, m, s, d, mo, y;
  logic [47:0] exp_q[$];
  string tag_q[$];
  bit sb_on = 0;
  logic [47:0] prev_v;

  always #2 clk = ~clk;

  cal_rtc i_cal_rtc (.*);

  function automatic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  always @(negedge clk) begin
    if (sb_on && {time_out, date_out} !== prev_v) begin
      if (exp_q.size() == 0) chk("R2 unexpected change", {time_out, date_out}, prev_v);
      else chk(tag_q.pop_front(), {time_out, date_out}, exp_q.pop_front());
    end
    prev_v = {time_out, date_out};
  end

  function automatic int mdays(int mm, int yy);
    if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
    return 31;
  endfunction

  task automatic tick_n(int n);
    @(negedge clk) tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic load_all(int hh, int mm, int ss, int dd, int mn, int yy);
    sb_on = 0;
    h = hh; m = mm; s = ss; d = dd; mo = mn; y = yy;
    @(negedge clk);
    time_in = {bcd(hh), bcd(mm), bcd(ss)};
    date_in = {bcd(yy), bcd(mn), bcd(dd)};
    load_time = 1; load_date = 1;
    @(negedge clk);
    load_time = 0; load_date = 0;
    chk("R5 load", {time_out, date_out}, {time_in, date_in});
    @(negedge clk);
    sb_on = 1;
  endtask

  task automatic step_secs(int n, string tag);
    for (int i = 0; i < n; i++) begin
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) begin h = 0; d++; end
      if (d > mdays(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
      exp_q.push_back({bcd(h), bcd(m), bcd(s), bcd(y), bcd(mo), bcd(d)});
      tag_q.push_back(tag);
      tick_n(128);
    end
    repeat (2) @(negedge clk);
    chk({tag, " queue drained"}, 48'(exp_q.size()), 48'd0);
  endtask

  task automatic count_until(bit flag_mode, output int n);
    logic [7:0] ref_s;
    ref_s = time_out[7:0];
    n = 0;
    forever begin
      @(negedge clk);
      if (flag_mode ? tick_flag : (time_out[7:0] != ref_s)) break;
      if (n > 1000) break;
      tick = 1;
      n++;
    end
    tick = 0;
  endtask

  task automatic tick_period(int sel);
    int n;
    @(negedge clk) tick_sel = 3'(sel);
    clr_tick = 1; @(negedge clk) clr_tick = 0;
    count_until(1, n);
    clr_tick = 1; @(negedge clk) clr_tick = 0;
    count_until(1, n);
    chk("R9 tick period", 48'(n), 48'(1 << sel));
  endtask

  task automatic set_hour12(int hh, logic [7:0] exp);
    @(negedge clk) time_in = {bcd(hh), 8'h00, 8'h00}; load_time = 1;
    @(negedge clk) load_time = 0;
    chk("R6 12h display", 48'(time_out[23:16]), 48'(exp));
  endtask

  initial begin
    int n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset time/date", {time_out, date_out}, {24'h000000, 24'h000101});
    chk("R1 reset flags", {46'd0, tick_flag, alarm_flag}, 48'd0);

    load_all(0, 0, 58, 1, 1, 0);   step_secs(3, "R2 sec/min carry");
    load_all(23, 59, 58, 28, 2, 0); step_secs(3, "R4 leap Feb 29");
    load_all(23, 59, 59, 29, 2, 24); step_secs(1, "R4 leap end Feb");
    load_all(23, 59, 59, 28, 2, 1); step_secs(1, "R3 common Feb 28");
    load_all(23, 59, 59, 30, 4, 5); step_secs(1, "R3 30-day month");
    load_all(23, 59, 59, 31, 1, 7); step_secs(1, "R3 31-day month");
    load_all(23, 59, 59, 31, 12, 99); step_secs(1, "R4 year 99 wrap");
    sb_on = 0;

    mode_12h = 1;
    set_hour12(0, 8'h12);
    set_hour12(11, 8'h11);
    set_hour12(12, 8'h92);
    set_hour12(13, 8'h81);
    set_hour12(23, 8'h91);
    mode_12h = 0;

    // R7 alarm with matching date
    load_all(10, 20, 30, 15, 6, 12);
    sb_on = 0;
    @(negedge clk) alarm_time_in = 24'h102032; alarm_date_in = 24'h120615; load_alarm = 1;
    @(negedge clk) load_alarm = 0;
    tick_n(128); repeat (2) @(negedge clk);
    chk("R7 no early alarm", 48'(alarm_flag), 48'd0);
    tick_n(128); repeat (2) @(negedge clk);
    chk("R7 alarm on match", 48'(alarm_flag), 48'd1);
    repeat (10) @(negedge clk);
    chk("R8 alarm sticky", 48'(alarm_flag), 48'd1);
    clr_alarm = 1; @(negedge clk) clr_alarm = 0;
    chk("R8 alarm cleared", 48'(alarm_flag), 48'd0);
    // R7 alarm with date mismatch
    load_all(10, 20, 31, 16, 6, 12);
    sb_on = 0;
    tick_n(128); repeat (2) @(negedge clk);
    chk("R7 date mismatch no alarm", 48'(alarm_flag), 48'd0);

    tick_period(0);
    tick_period(3);
    tick_period(7);
    repeat (5) @(negedge clk);
    chk("R8 tick sticky", 48'(tick_flag), 48'd1);

    load_all(1, 0, 0, 1, 1, 1);
    sb_on = 0;
    count_until(0, n1);
    chk("R2 128 ticks after load", 48'(n1), 48'd128);
    @(negedge clk) trim = 8'd64;
    count_until(0, n1); count_until(0, n1);
    chk("R10 trim +64", 48'(n1), 48'd129);
    @(negedge clk) trim = 8'hC0;
    count_until(0, n1); count_until(0, n1);
    chk("R10 trim -64", 48'(n1), 48'd127);
    @(negedge clk) trim = 8'd32;
    count_until(0, n1); count_until(0, n1); count_until(0, n2);
    chk("R10 trim +32 pair", 48'(n1 + n2), 48'd257);
    @(negedge clk) trim = 8'd0;

    finish_sim();
  end
endmodule